// File: doc/BRIEF.md
# Three-Bus Datapath with Step Sequencer

This block is a small processor datapath built around three internal buses. Buses A and B carry operands into an adder-based ALU, and bus C carries the ALU result back to a destination. Several storage elements hang off the buses: a program counter, a memory address register, a memory data register, an instruction register, and an eight-entry general register file. The register file has two independent read ports, so two registers can drive A and B in the same step. A step sequencer drives every bus select and load enable. It runs one control step per clock and supports three flows: instruction fetch, register-to-register add, and load from memory.

The program counter is incremented inside the first fetch step. The PC goes onto bus A, the ALU adds the constant one, and bus C writes the sum straight back into the PC. No temporary latch is involved. Memory is a synchronous read port: a one-cycle read strobe with an address, and a ready pulse that arrives with the data. The sequencer publishes its step counter and a one-cycle done pulse. An observation port lets the general registers be read from outside.

Instruction word, 16 bits:
- Bits [15:12] hold the opcode: 0001 is add, 0010 is load, and every other value is a no-op.
- For add, [11:8] names the destination, [7:4] the first source and [3:0] the second source. Only the low three bits of each field select a register.
- For load, [11:8] names the destination and [7:0] is a word address, zero-extended to the 12-bit memory address.

States and transitions:
- FETCH_ADDR → FETCH_WAIT, always.
- FETCH_WAIT stays in FETCH_WAIT until ready, then goes to FETCH_IR.
- FETCH_IR branches on the opcode: to EXEC_ADD for add, to LOAD_ADDR for load, and back to FETCH_ADDR for a no-op (done asserted).
- EXEC_ADD → FETCH_ADDR (done asserted).
- LOAD_ADDR → LOAD_WAIT.
- LOAD_WAIT stays in LOAD_WAIT until ready, then goes to LOAD_WB.
- LOAD_WB → FETCH_ADDR (done asserted).

Top module: `tribus_cpu`

## Requirements
- R1: While reset is held, the PC reads 0, the step counter reads 0, done and the read strobe are low, and every general register reads 0.
- R2: The first fetch step puts the PC on bus A into the address register, issues a read of that address (strobe high on the next cycle), and writes PC+1 back to the PC in that same step. One fetch raises the PC by exactly one.
- R3: Fetch holds in its wait step until memory ready, captures the returned word, then moves it to the instruction register in one more step. With L the number of cycles from the read strobe to ready, fetch takes 3+L cycles.
- R4: ADD writes (Rs1 + Rs2) mod 2^16 into Rd in a single execute step, so the instruction takes 4+L cycles.
- R5: An ADD whose two sources are the same register, possibly also the destination, reads that register's old value on both buses.
- R6: LOAD presents the 8-bit address field, zero-extended, on the memory address during its second read, and writes the returned word into Rd. It takes 6+Lf+Ld cycles, where Lf and Ld are the latencies of the fetch read and the data read.
- R7: Any opcode other than 0001 and 0010 changes no general register and completes in 3+L cycles.
- R8: The step counter reads 0 in the first fetch step and rises by one each cycle. Done is high for exactly the last cycle of each instruction.
- R9: The read strobe is high for one cycle per read: one read for ADD and no-op, two for LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address (from the address register) |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Read data valid pulse |
| obs_sel | input | 3 | General register selected for observation |
| obs_data | output | 16 | Contents of the observed register |
| pc_out | output | 12 | Program counter |
| step_no | output | 8 | Control step within the current instruction |
| instr_done | output | 1 | High during the last step of an instruction |

## Verification
Some properties are checked every cycle by assertions: the fetch-address step is always followed by the wait step, the wait steps hold until ready, the step counter rises by one until done, every PC load adds exactly one, and the read strobe never lasts two cycles. Other behaviour can only be shown by the bench's scenarios. These include the arithmetic results with wraparound, same-register operands, load data and address, the untouched registers after a no-op, and per-instruction cycle counts under memory latencies of one to three cycles.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

    localparam logic [3:0] OPC_ADD  = 4'b0001;
    localparam logic [3:0] OPC_LOAD = 4'b0010;

    typedef enum logic [2:0] {
        FETCH_ADDR,
        FETCH_WAIT,
        FETCH_IR,
        EXEC_ADD,
        LOAD_ADDR,
        LOAD_WAIT,
        LOAD_WB
    } step_e;

    typedef enum logic [1:0] {A_NONE, A_PC, A_REG, A_IRADDR} asel_e;
    typedef enum logic [1:0] {B_NONE, B_MDR, B_REG} bsel_e;
    typedef enum logic {ALU_ADD, ALU_PASSB} aluop_e;

    typedef struct packed {
        asel_e  a_sel;
        bsel_e  b_sel;
        logic   const_sel;
        aluop_e alu_op;
        logic   pc_ld;
        logic   mar_ld;
        logic   mdr_ld;
        logic   ir_ld;
        logic   rf_we;
        logic   rd_issue;
        logic   done;
    } ctl_t;

endpackage

// File: rtl/tribus_alu.sv
module tribus_alu
    import tribus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  aluop_e        op,
    output logic [DW-1:0] res
);
    always_comb begin
        unique case (op)
            ALU_ADD:   res = opa + opb;
            ALU_PASSB: res = opb;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/tribus_rf.sv
module tribus_rf #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RA_W = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RA_W-1:0] wa,
    input  logic [DW-1:0]   wd,
    input  logic [RA_W-1:0] ra_a,
    input  logic [RA_W-1:0] ra_b,
    input  logic [RA_W-1:0] ra_o,
    output logic [DW-1:0]   rd_a,
    output logic [DW-1:0]   rd_b,
    output logic [DW-1:0]   rd_o
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && wa == RA_W'(g))
                regs[g] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_o = regs[ra_o];
endmodule

// File: rtl/tribus_seq.sv
module tribus_seq
    import tribus_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ready,
    input  logic [3:0]        opc_mdr,
    output ctl_t              ctl,
    output logic [STEP_W-1:0] step_no
);
    step_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= FETCH_ADDR;
            step_no <= '0;
        end else begin
            state   <= state_nx;
            step_no <= (state_nx == FETCH_ADDR) ? '0 : step_no + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        ctl      = '0;
        unique case (state)
            FETCH_ADDR: begin
                ctl.a_sel     = A_PC;
                ctl.mar_ld    = 1'b1;
                ctl.rd_issue  = 1'b1;
                ctl.const_sel = 1'b1;
                ctl.alu_op    = ALU_ADD;
                ctl.pc_ld     = 1'b1;
                state_nx      = FETCH_WAIT;
            end
            FETCH_WAIT: begin
                if (mem_ready) begin
                    ctl.mdr_ld = 1'b1;
                    state_nx   = FETCH_IR;
                end
            end
            FETCH_IR: begin
                ctl.b_sel  = B_MDR;
                ctl.alu_op = ALU_PASSB;
                ctl.ir_ld  = 1'b1;
                if (opc_mdr == OPC_ADD)
                    state_nx = EXEC_ADD;
                else if (opc_mdr == OPC_LOAD)
                    state_nx = LOAD_ADDR;
                else begin
                    ctl.done = 1'b1;
                    state_nx = FETCH_ADDR;
                end
            end
            EXEC_ADD: begin
                ctl.a_sel  = A_REG;
                ctl.b_sel  = B_REG;
                ctl.alu_op = ALU_ADD;
                ctl.rf_we  = 1'b1;
                ctl.done   = 1'b1;
                state_nx   = FETCH_ADDR;
            end
            LOAD_ADDR: begin
                ctl.a_sel    = A_IRADDR;
                ctl.mar_ld   = 1'b1;
                ctl.rd_issue = 1'b1;
                state_nx     = LOAD_WAIT;
            end
            LOAD_WAIT: begin
                if (mem_ready) begin
                    ctl.mdr_ld = 1'b1;
                    state_nx   = LOAD_WB;
                end
            end
            LOAD_WB: begin
                ctl.b_sel  = B_MDR;
                ctl.alu_op = ALU_PASSB;
                ctl.rf_we  = 1'b1;
                ctl.done   = 1'b1;
                state_nx   = FETCH_ADDR;
            end
            default: state_nx = FETCH_ADDR;
        endcase
    end

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == FETCH_ADDR |=> state == FETCH_WAIT);

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FETCH_WAIT || state == LOAD_WAIT) && !mem_ready) |=> $stable(state));

    // R8
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.done |=> step_no == $past(step_no) + 1'b1);
endmodule

// File: rtl/tribus_cpu.sv
module tribus_cpu
    import tribus_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 12,
    parameter int NREG   = 8,
    parameter int STEP_W = 8,
    parameter int LDA_W  = 8,
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready,
    input  logic [RA_W-1:0]   obs_sel,
    output logic [DW-1:0]     obs_data,
    output logic [AW-1:0]     pc_out,
    output logic [STEP_W-1:0] step_no,
    output logic              instr_done
);
    ctl_t          ctl;
    logic [AW-1:0] pc, mar;
    logic [DW-1:0] mdr, ir;
    logic [DW-1:0] bus_a, bus_b, bus_c, alu_b;
    logic [DW-1:0] rf_a, rf_b;

    tribus_seq #(.STEP_W(STEP_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_ready (mem_ready),
        .opc_mdr   (mdr[DW-1 -: 4]),
        .ctl       (ctl),
        .step_no   (step_no)
    );

    tribus_rf #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.rf_we),
        .wa    (ir[8 +: RA_W]),
        .wd    (bus_c),
        .ra_a  (ir[4 +: RA_W]),
        .ra_b  (ir[0 +: RA_W]),
        .ra_o  (obs_sel),
        .rd_a  (rf_a),
        .rd_b  (rf_b),
        .rd_o  (obs_data)
    );

    always_comb begin
        unique case (ctl.a_sel)
            A_PC:     bus_a = DW'(pc);
            A_REG:    bus_a = rf_a;
            A_IRADDR: bus_a = DW'(ir[LDA_W-1:0]);
            default:  bus_a = '0;
        endcase
        unique case (ctl.b_sel)
            B_MDR:   bus_b = mdr;
            B_REG:   bus_b = rf_b;
            default: bus_b = '0;
        endcase
        alu_b = ctl.const_sel ? DW'(1) : bus_b;
    end

    tribus_alu #(.DW(DW)) u_alu (
        .opa (bus_a),
        .opb (alu_b),
        .op  (ctl.alu_op),
        .res (bus_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= '0;
            mar    <= '0;
            mdr    <= '0;
            ir     <= '0;
            mem_rd <= 1'b0;
        end else begin
            if (ctl.pc_ld)  pc  <= bus_c[AW-1:0];
            if (ctl.mar_ld) mar <= bus_a[AW-1:0];
            if (ctl.mdr_ld) mdr <= mem_rdata;
            if (ctl.ir_ld)  ir  <= bus_c;
            mem_rd <= ctl.rd_issue;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{ir, bus_a, bus_c};

    assign mem_addr   = mar;
    assign pc_out     = pc;
    assign instr_done = ctl.done;

    // R2
    pc_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_ld |=> pc_out == $past(pc_out) + 1'b1);

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
endmodule

// File: tb/tribus_cpu_tb.sv
`timescale 1ns/1ps
module tribus_cpu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata;
    logic        mem_ready;
    logic [2:0]  obs_sel;
    logic [15:0] obs_data;
    logic [11:0] pc_out;
    logic [7:0]  step_no;
    logic        instr_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tribus_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .obs_sel(obs_sel),
        .obs_data(obs_data), .pc_out(pc_out), .step_no(step_no),
        .instr_done(instr_done)
    );

    typedef struct {
        int          cyc;
        int          reads;
        int          ridx;
        logic [15:0] val;
        int          pc;
        int          addr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] mem [256];
    logic [15:0] mdl_rf [8];
    int          mdl_pc = 0;

    function automatic int lat(input int a);
        return 1 + (a % 3);
    endfunction

    // memory model: ready pulses lat(addr) cycles after the strobe cycle
    logic [7:0] pend_addr;
    int         pend_cnt;
    bit         pend;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            pend      <= 0;
            pend_cnt  <= 0;
            pend_addr <= '0;
        end else begin
            mem_ready <= 1'b0;
            if (mem_rd) begin
                if (lat(int'(mem_addr)) == 1) begin
                    mem_ready <= 1'b1;
                    mem_rdata <= mem[mem_addr[7:0]];
                end else begin
                    pend      <= 1;
                    pend_addr <= mem_addr[7:0];
                    pend_cnt  <= lat(int'(mem_addr)) - 2;
                end
            end else if (pend) begin
                if (pend_cnt == 0) begin
                    mem_ready <= 1'b1;
                    mem_rdata <= mem[pend_addr];
                    pend      <= 0;
                end else
                    pend_cnt <= pend_cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver: places one instruction and pushes its expected result
    task automatic put(input logic [15:0] w);
        exp_t e;
        int op = int'(w[15:12]);
        int d = int'(w[10:8]);
        mem[mdl_pc] = w;
        e.ridx = d;
        e.addr = -1;
        if (op == 1) begin
            mdl_rf[d] = mdl_rf[w[6:4]] + mdl_rf[w[2:0]];
            e.cyc = 4 + lat(mdl_pc);
            e.reads = 1;
            e.tag = (w[6:4] == w[2:0]) ? "R5" : "R4";
        end else if (op == 2) begin
            mdl_rf[d] = mem[w[7:0]];
            e.cyc = 6 + lat(mdl_pc) + lat(int'(w[7:0]));
            e.reads = 2;
            e.addr = int'(w[7:0]);
            e.tag = "R6";
        end else begin
            e.cyc = 3 + lat(mdl_pc);
            e.reads = 1;
            e.tag = "R7";
        end
        e.val = mdl_rf[d];
        mdl_pc++;
        e.pc = mdl_pc;
        sb.push_back(e);
    endtask

    // monitor: pops expectations as instructions complete
    initial begin
        int nrd = 0;
        int last_addr = -1;
        exp_t e;
        obs_sel = '0;
        @(posedge rst_n);
        while (sb.size() > 0) begin
            @(negedge clk);
            if (mem_rd) begin
                nrd++;
                last_addr = int'(mem_addr);
            end
            if (instr_done) begin
                e = sb.pop_front();
                check(int'(step_no) + 1 == e.cyc, {e.tag, " R3 R8 cycle count"}, int'(step_no) + 1, e.cyc);
                check(nrd == e.reads, "R9 read strobes", nrd, e.reads);
                if (e.addr >= 0)
                    check(last_addr == e.addr, "R6 load address", last_addr, e.addr);
                obs_sel = 3'(e.ridx);
                @(negedge clk);
                check(obs_data == e.val, {e.tag, " register value"}, int'(obs_data), int'(e.val));
                check(int'(pc_out) == e.pc, "R2 pc after instruction", int'(pc_out), e.pc);
                check(!instr_done, "R8 done single cycle", int'(instr_done), 0);
                nrd = 0;
            end
        end
        finished = 1;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) mdl_rf[i] = '0;
        mem[8'h80] = 16'h1234;
        mem[8'h81] = 16'h0F0F;
        mem[8'h82] = 16'hFFFF;
        mem[8'hFF] = 16'hBEEF;
        put(16'h2180);   // LOAD R1,[0x80]
        put(16'h2281);   // LOAD R2,[0x81]
        put(16'h1312);   // ADD  R3,R1,R2
        put(16'h1333);   // ADD  R3,R3,R3
        put(16'h2482);   // LOAD R4,[0x82]
        put(16'h1542);   // ADD  R5,R4,R2 (wraps)
        put(16'hF500);   // no-op, R5 must hold
        put(16'h0777);   // opcode 0 no-op, R7 must stay 0
        put(16'h27FF);   // LOAD R7,[0xFF]
        put(16'h1071);   // ADD  R0,R7,R1
        put(16'h1600);   // ADD  R6,R0,R0
        put(16'h2100);   // LOAD R1,[0x00]

        // R1 reset state
        repeat (3) @(negedge clk);
        check(pc_out == 0, "R1 pc in reset", int'(pc_out), 0);
        check(step_no == 0, "R1 step in reset", int'(step_no), 0);
        check(!instr_done && !mem_rd, "R1 done/strobe in reset", int'({instr_done, mem_rd}), 0);
        for (int i = 0; i < 8; i++) begin
            obs_sel = 3'(i);
            #0.1;
            check(obs_data == 0, "R1 register in reset", int'(obs_data), 0);
        end
        rst_n = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule